// File: doc/BRIEF.md
# Size-Encoded Field Address Decoder

This block turns a size-encoded field address into the aligned start bit address of the field, its width in bits, and the byte lanes that the field occupies on a 128-bit data bus. The encoded address is one bit wider than a plain bit address. The number of consecutive ones at its least significant end, up to the first zero, gives the base-two logarithm of the field width. The bits above that terminating zero form the bit address. A trailing-ones count of zero means a single bit, and a count of seven means a 128-bit field.

Because a field of width 2^t always starts on a 2^t boundary, the low t bits of the decoded address are forced to zero. A code whose trailing ones run past seven is rejected; this includes a code made entirely of ones. The decode is combinational and the results are registered, so a request presented with `in_valid` appears one clock later with `out_valid`. The block does not access memory. A load/store unit or bus bridge uses the outputs to steer data.

Top module: `field_addr_decoder`

## Requirements
- R1: The field width `out_width` equals 2^t, where t is the number of consecutive ones counted up from bit 0 of `in_code` before the first zero, for t from 0 to 7 (width 1 to 128).
- R2: `out_addr` holds `in_code[ADDR_W:1]`, the code shifted right by one, with only the alignment clearing of R3 applied.
- R3: For a field of width 2^t, bits t-1..0 of `out_addr` are zero.
- R4: A code whose trailing-ones count exceeds 7, including an all-ones code, sets `out_err` to 1 and drives `out_addr`, `out_width` and `out_lanes` to zero. Valid codes give `out_err` = 0.
- R5: For fields of 1, 2 or 4 bits, `out_lanes` has exactly one bit set, at lane index `out_addr[6:3]`. Lane i covers bus bits 8i to 8i+7, and the bus offset is `out_addr` modulo 128.
- R6: For fields of 8 bits or more, `out_lanes` sets 2^(t-3) contiguous lanes starting at lane `out_addr[6:3]`. A 128-bit field sets all 16 lanes.
- R7: Outputs appear one clock after the input is sampled. `out_valid` equals `in_valid` of the previous cycle.
- R8: While `rst_n` is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present on `in_code` |
| in_code | input | ADDR_W+1 (33) | Size-encoded field address |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_err | output | 1 | Code has no terminating zero within 8 bits |
| out_addr | output | ADDR_W (32) | Aligned start bit address |
| out_width | output | MAX_LOG+1 (8) | Field width in bits, one-hot |
| out_lanes | output | BUS_W/8 (16) | Byte-lane select mask |

## Verification
The bench fills the address bits above the terminator with ones, so any bit left uncleared below the alignment boundary shows up in `out_addr`. A decoder that shifted the code wrongly, or that kept one bit of address too many, would report a misaligned start. It walks every width from 1 to 128 bits and places sub-byte fields in the top lanes, which exposes a lane mask that is shifted, one lane too narrow, or that wraps the bus offset incorrectly. It also drives codes with exactly eight trailing ones and with all ones, where a counter that saturates or drops its top bit would accept the code as a 128-bit field. Gaps in `in_valid` show whether the valid flag is delayed by exactly one cycle rather than held.

// File: rtl/fad_pkg.sv
// Package: constants shared by the field address decoder.
// Assumes byte lanes are eight bits wide on every bus this block serves.
package fad_pkg;
    localparam int LANE_BITS     = 8;
    localparam int LANE_LOG      = 3;
endpackage

// File: rtl/fad_trailing_ones.sv
// Counts consecutive ones from bit 0 of a code up to the first zero.
// Assumes CODE_W >= 1; the count saturates naturally at CODE_W.
module fad_trailing_ones #(
    parameter int CODE_W = 33,
    localparam int CNT_W = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  count
);
    // Walk upward while the run of ones is unbroken.
    always_comb begin
        logic alive;
        alive = 1'b1;
        count = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (alive && code[i]) count = count + 1'b1;
            else                  alive = 1'b0;
        end
    end
endmodule

// File: rtl/fad_lane_mask.sv
// Builds the byte-lane select mask for a naturally aligned field.
// Assumes BUS_W is a power of two, at least 8 and at least 2**MAX_LOG,
// and that off is already aligned to the field width.
module fad_lane_mask
    import fad_pkg::*;
#(
    parameter int BUS_W   = 128,
    parameter int MAX_LOG = 7,
    localparam int OFF_W  = $clog2(BUS_W),
    localparam int LOG_W  = $clog2(MAX_LOG + 1),
    localparam int LANES  = BUS_W / LANE_BITS,
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LOG_W-1:0] log2w,
    output logic [LANES-1:0] mask
);
    logic [LIDX_W-1:0] start_lane;
    logic [LIDX_W-1:0] span;

    // Start lane is the bus offset with the in-lane bits dropped.
    assign start_lane = LIDX_W'(off >> LANE_LOG);

    // Lane index bits that the field spans (none below one byte).
    always_comb begin
        for (int j = 0; j < LIDX_W; j++)
            span[j] = (int'(log2w) >= LANE_LOG) && (j < int'(log2w) - LANE_LOG);
    end

    // A lane is selected when it matches the start lane outside the span bits.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (((LIDX_W'(i)) ^ start_lane) & ~span) == '0;
    end
endmodule

// File: rtl/field_addr_decoder.sv
// Decodes a size-encoded field address (trailing-ones width code plus
// bit address) into aligned start address, width and byte-lane mask.
// Assumes ADDR_W >= $clog2(BUS_W); outputs registered, one cycle latency.
module field_addr_decoder
    import fad_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BUS_W   = 128,
    parameter int MAX_LOG = 7,
    localparam int CODE_W = ADDR_W + 1,
    localparam int CNT_W  = $clog2(CODE_W + 1),
    localparam int LOG_W  = $clog2(MAX_LOG + 1),
    localparam int OFF_W  = $clog2(BUS_W),
    localparam int WID_W  = MAX_LOG + 1,
    localparam int LANES  = BUS_W / LANE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W:0]   in_code,
    output logic              out_valid,
    output logic              out_err,
    output logic [ADDR_W-1:0] out_addr,
    output logic [WID_W-1:0]  out_width,
    output logic [LANES-1:0]  out_lanes
);
    logic [CNT_W-1:0]  ones;
    logic              bad;
    logic [LOG_W-1:0]  log2w;
    logic [ADDR_W-1:0] low_clear;
    logic [ADDR_W-1:0] base;
    logic [LANES-1:0]  lanes;

    fad_trailing_ones #(.CODE_W(CODE_W)) u_ones (
        .code  (in_code),
        .count (ones)
    );

    // Reject codes whose run of ones is longer than the widest field.
    assign bad   = ones > CNT_W'(MAX_LOG);
    assign log2w = LOG_W'(ones);

    // Mask of address bits below the field's alignment boundary.
    always_comb begin
        for (int i = 0; i < ADDR_W; i++)
            low_clear[i] = (i < int'(ones));
    end

    assign base = in_code[ADDR_W:1] & ~low_clear;

    fad_lane_mask #(.BUS_W(BUS_W), .MAX_LOG(MAX_LOG)) u_lanes (
        .off   (base[OFF_W-1:0]),
        .log2w (log2w),
        .mask  (lanes)
    );

    // Output register: valid always follows, data loads on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
            out_width <= '0;
            out_lanes <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_err   <= bad;
                out_addr  <= bad ? '0 : base;
                out_width <= bad ? '0 : (WID_W'(1) << log2w);
                out_lanes <= bad ? '0 : lanes;
            end
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_lanes == '0 && out_width == '0 && out_addr == '0));
    // R1
    width_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> ($countones(out_width) == 1));
    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> ((out_addr & (ADDR_W'(out_width) - 1'b1)) == '0));
    // R6
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |->
        ($countones(out_lanes) == ((out_width < WID_W'(LANE_BITS)) ? 1 : int'(out_width) / LANE_BITS)));
endmodule

// File: tb/field_addr_decoder_test.sv
module field_addr_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW:0]   in_code = '0;
    logic          out_valid, out_err;
    logic [AW-1:0] out_addr;
    logic [7:0]    out_width;
    logic [15:0]   out_lanes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    field_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr),
        .out_width(out_width), .out_lanes(out_lanes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Build a code from address bits and a width log.
    function automatic logic [AW:0] mk(logic [AW-1:0] a, int t);
        logic [AW:0] c;
        c = {a, 1'b0};
        c = c & ~((33'(1) << (t + 1)) - 1);
        c = c | ((33'(1) << t) - 1);
        return c;
    endfunction

    // Apply one request and compare with values from the requirements.
    task automatic run(string req, logic [AW:0] code);
        int t; logic [AW-1:0] base; int off; int nl; int mask; bit bad;
        t = 0;
        while (t <= AW && code[t]) t++;
        bad = (t > 7);
        base = code[AW:1];
        for (int i = 0; i < t && i < AW; i++) base[i] = 1'b0;
        off = int'(base[6:0]);
        nl = (t < 3) ? 1 : (1 << (t - 3));
        mask = ((1 << nl) - 1) << (off >> 3);
        @(negedge clk); in_valid = 1'b1; in_code = code;
        @(negedge clk); in_valid = 1'b0;
        check("R7", "out_valid", out_valid, 1);
        check("R4", "out_err", out_err, bad);
        if (bad) begin
            check("R4", "addr", out_addr, 0);
            check("R4", "width", out_width, 0);
            check("R4", "lanes", out_lanes, 0);
        end else begin
            check(req, "addr", out_addr, base);
            check("R1", "width", out_width, 1 << t);
            check(t < 3 ? "R5" : "R6", "lanes", out_lanes, mask & 16'hFFFF);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "valid", out_valid, 0);
        check("R8", "lanes", out_lanes, 0);
        check("R8", "width", out_width, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_single_bit();
        run("R2", mk(32'h0000_1234, 0));
        run("R2", mk(32'hDEAD_BEEF, 0));
        run("R5", mk(32'h0000_007F, 0)); // top lane 15
    endtask

    task automatic t_all_widths();
        for (int t = 0; t <= 7; t++) begin
            run("R3", mk(32'hFFFF_FFFF, t)); // ones below boundary must clear
            run("R6", mk(32'h0000_0050, t));
        end
    endtask

    task automatic t_lane_placement();
        run("R5", mk(32'h0000_0044, 2)); // 4-bit in lane 8
        run("R6", mk(32'h0000_0130, 4)); // 16-bit, lanes 6..7
        run("R6", mk(32'h0000_0FC0, 6)); // 64-bit upper half
    endtask

    task automatic t_invalid();
        run("R4", 33'h0_0000_00FF);      // exactly eight ones
        run("R4", 33'h1_FFFF_FFFF);      // all ones
        run("R4", 33'h1_2345_61FF);
    endtask

    task automatic t_valid_gap();
        @(negedge clk);
        check("R7", "valid after gap", out_valid, 0);
        in_valid = 1'b1; in_code = mk(32'h10, 3);
        @(negedge clk); in_code = mk(32'h20, 1);
        check("R7", "first of pair", out_addr, 32'h10);
        @(negedge clk); in_valid = 1'b0;
        check("R7", "second of pair", out_addr, 32'h20);
        check("R7", "valid held", out_valid, 1);
        @(negedge clk);
        check("R7", "valid dropped", out_valid, 0);
    endtask

    initial begin
        t_reset();
        t_single_bit();
        t_all_widths();
        t_lane_placement();
        t_invalid();
        t_valid_gap();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule